// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block produces the bus strobes and the multiplexed address/data traffic of a byte-wide processor that runs its code from an external program memory and reaches an external data memory over the same pins. Time is split into machine cycles of twelve clocks. Each clock stands for one oscillator period. Every machine cycle has two address-latch pulses. When code is being fetched, a program-read strobe follows each latch pulse. The low address byte and the data share one 8-bit bus, and the high address byte has a port of its own.

A small request port stands in for the processor core. Once per machine cycle the sequencer offers a slot. It then takes one of three requests: a plain code fetch of two consecutive bytes, a data read, or a data write. A data access lasts two machine cycles. One code byte is fetched in the first half and one in the last half. In between, a latch pulse and two program-read pulses are dropped to make room for a six-clock read or write strobe. The data address is either a full 16-bit pointer or an 8-bit offset. With the 8-bit offset, the high byte comes from a port register value that the core supplies. Fetched code bytes and read data come back with one-clock valid pulses.

Top module: `extbus_sequencer`

## Requirements
- R1: A machine cycle is 12 clocks long, with phases 0 to 11. The address latch strobe `ale_o` is high in phases 0-1 and 6-7 and low in all other phases, so each pulse is exactly 2 clocks wide. It keeps this cadence in idle cycles.
- R2: In a fetch cycle, `psen_n_o` is low in phases 3-5 and 9-11, so each pulse is exactly 3 clocks wide. The first half reads the request address P and the second half reads P+1, wrapping modulo 2^16. Each byte sampled from `ad_i` in the last clock of a program-read pulse appears on `code_o` with a one-clock `code_vld_o` on the following clock. `psen_n_o` is never low while `ale_o` is high.
- R3: In a machine cycle that carries no request, `psen_n_o`, `rd_n_o` and `wr_n_o` stay high and `ad_oe_o` stays low.
- R4: A data request (`req_op` 2'b01 read, 2'b10 write) takes two machine cycles. The first cycle fetches P in its first half. Its second latch pulse carries the data address, and no program-read pulse follows it. The second cycle has no latch pulse in phases 0-1 and no program-read pulse in phases 3-5. It fetches P+1 in its second half. Over the two cycles there are 3 latch pulses and 6 program-read clocks.
- R5: When `req_wide` is 1, the data address is `req_ptr`. Its high byte is on `addr_hi_o` and its low byte is on `ad_o` when `ale_o` falls.
- R6: When `req_wide` is 0, the high byte of the data address is `req_port2` and the low byte is `req_ptr[7:0]`.
- R7: In a data read, `rd_n_o` is low for phases 0-5 of the second cycle, which is 6 clocks. `ad_oe_o` is low from phase 9 of the first cycle until the strobe ends. The byte on `ad_i` in the last strobe clock appears on `rdata_o` with a one-clock `rdata_vld_o`.
- R8: In a data write, `wr_n_o` is low for phases 0-5 of the second cycle, which is 6 clocks. `ad_o` drives `req_wdata` with `ad_oe_o` high throughout. `rd_n_o` and `wr_n_o` are never low together.
- R9: During each latch pulse and the clock after it, `ad_oe_o` is high and `ad_o` holds the low address byte. `addr_hi_o` holds the high byte.
- R10: `req_ready` is high only in phase 11 of a cycle that is not the first cycle of a data access. A request is taken only when `req_ready` and `req_valid` are both high, and requests at other times are ignored. While reset is held, the phase counter sits at 11, `req_ready` is 1 and all strobes are inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-period clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 00 fetch, 01 data read, 10 data write |
| req_pc | input | 16 | Code address of the first byte to fetch |
| req_ptr | input | 16 | Data pointer; only the low byte is used for the 8-bit form |
| req_wide | input | 1 | 1: 16-bit pointer form, 0: 8-bit register-indirect form |
| req_port2 | input | 8 | Port register value used as the high byte for the 8-bit form |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Slot offered this clock |
| ale_o | output | 1 | Address latch enable, active high |
| psen_n_o | output | 1 | Program-memory read strobe, active low |
| rd_n_o | output | 1 | Data read strobe, active low |
| wr_n_o | output | 1 | Data write strobe, active low |
| ad_o | output | 8 | Multiplexed low address / write data out |
| ad_oe_o | output | 1 | Drive enable for `ad_o`; low means the bus floats |
| ad_i | input | 8 | Multiplexed bus input (code and read data) |
| addr_hi_o | output | 8 | High address byte |
| code_o | output | 8 | Fetched code byte |
| code_vld_o | output | 1 | One-clock pulse marking a new `code_o` |
| rdata_o | output | 8 | Byte read from data memory |
| rdata_vld_o | output | 1 | One-clock pulse marking a new `rdata_o` |

## Verification
A wrong phase count or cycle type shows up on the strobes within the same machine cycle. A latch pulse or program-read pulse appears where it should be skipped, or one is missing, or a pulse width drifts away from 2 or 3 clocks. A wrong address selection shows up at the next falling edge of the latch strobe, no more than six clocks later. An external memory model latches the address at that edge and answers with a byte computed from it, so a wrong address or wrong address order also comes back as a wrong code or read byte one clock after the strobe ends. A mistake in the bus-enable logic shows up as the bus being driven while a read strobe is low, or as write data missing during the write strobe.

// File: rtl/mxb_pkg.sv
`timescale 1ns/1ps
package mxb_pkg;
    localparam int AW      = 16;
    localparam int DW      = 8;
    localparam int MC_LEN  = 12;
    localparam int HALF    = MC_LEN / 2;
    localparam int ALE_LEN = 2;
    localparam int ADR_LEN = 3;
    localparam int PW      = $clog2(MC_LEN);

    typedef logic [PW-1:0] phase_t;

    typedef enum logic [1:0] {CY_IDLE, CY_FETCH, CY_DACC1, CY_DACC2} cyc_e;
    typedef enum logic [1:0] {OP_FETCH = 2'b00, OP_DRD = 2'b01, OP_DWR = 2'b10, OP_NONE = 2'b11} op_e;

    typedef struct packed {
        logic [AW-1:0] pc;
        logic [AW-1:0] dadr;
        logic          wr;
        logic [DW-1:0] wdata;
    } acc_t;

    function automatic phase_t half_pos(phase_t p);
        return (p >= phase_t'(HALF)) ? p - phase_t'(HALF) : p;
    endfunction
endpackage

// File: rtl/mxb_phase.sv
`timescale 1ns/1ps
module mxb_phase
    import mxb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_t phase,
    output logic   last
);
    assign last = (phase == phase_t'(MC_LEN-1));

    always_ff @(posedge clk) begin
        if (rst)       phase <= phase_t'(MC_LEN-1);
        else if (last) phase <= '0;
        else           phase <= phase + phase_t'(1);
    end
endmodule

// File: rtl/mxb_ctrl.sv
`timescale 1ns/1ps
module mxb_ctrl
    import mxb_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          last,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_pc,
    input  logic [AW-1:0] req_ptr,
    input  logic          req_wide,
    input  logic [DW-1:0] req_port2,
    input  logic [DW-1:0] req_wdata,
    output cyc_e          cyc,
    output acc_t          acc,
    output logic          ready
);
    op_e op;
    assign op    = op_e'(req_op);
    assign ready = last && (cyc != CY_DACC1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc <= CY_IDLE;
            acc <= '0;
        end else if (last) begin
            if (cyc == CY_DACC1) begin
                cyc <= CY_DACC2;
            end else if (req_valid && op != OP_NONE) begin
                cyc       <= (op == OP_FETCH) ? CY_FETCH : CY_DACC1;
                acc.pc    <= req_pc;
                acc.dadr  <= req_wide ? req_ptr : {req_port2, req_ptr[DW-1:0]};
                acc.wr    <= (op == OP_DWR);
                acc.wdata <= req_wdata;
            end else begin
                cyc <= CY_IDLE;
            end
        end
    end

    // R4
    dacc_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc == CY_DACC2) |-> ($past(cyc) == CY_DACC1 || $past(cyc) == CY_DACC2));
    // R10
    no_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (last && cyc == CY_DACC1 && req_valid) |=> (cyc == CY_DACC2));
endmodule

// File: rtl/mxb_drive.sv
`timescale 1ns/1ps
module mxb_drive
    import mxb_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  phase_t        phase,
    input  cyc_e          cyc,
    input  acc_t          acc,
    output logic          ale,
    output logic          psen_n,
    output logic          rd_n,
    output logic          wr_n,
    output logic [DW-1:0] ad_o,
    output logic          ad_oe,
    output logic [DW-1:0] addr_hi
);
    phase_t        hp;
    logic          sec, slot_ale, slot_adr, fetch_slot, strobe_win;
    logic [AW-1:0] pc_nx, cur;

    assign hp       = half_pos(phase);
    assign sec      = (phase >= phase_t'(HALF));
    assign slot_ale = (hp < phase_t'(ALE_LEN));
    assign slot_adr = (hp < phase_t'(ADR_LEN));
    assign pc_nx    = acc.pc + AW'(1);

    always_comb begin
        fetch_slot = sec ? (cyc == CY_FETCH || cyc == CY_DACC2)
                         : (cyc == CY_FETCH || cyc == CY_DACC1);
        strobe_win = (cyc == CY_DACC2) && !sec;
        ale    = slot_ale && !strobe_win;
        psen_n = !(fetch_slot && !slot_adr);
        rd_n   = !(strobe_win && !acc.wr);
        wr_n   = !(strobe_win && acc.wr);
        cur    = acc.pc;
        ad_o   = '0;
        ad_oe  = 1'b0;
        if (fetch_slot) begin
            cur   = sec ? pc_nx : acc.pc;
            ad_o  = cur[DW-1:0];
            ad_oe = slot_adr;
        end else if (cyc == CY_DACC1 || strobe_win) begin
            cur   = acc.dadr;
            ad_o  = (slot_adr && !strobe_win) ? acc.dadr[DW-1:0] : acc.wdata;
            ad_oe = (slot_adr && !strobe_win) || acc.wr;
        end
        addr_hi = cur[AW-1:DW];
    end

    // R1
    ale_width_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ale) |=> ale ##1 !ale);
    // R2
    psen_width_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(psen_n) |=> !psen_n ##1 !psen_n ##1 psen_n);
    // R2
    ale_psen_chk: assert property (@(posedge clk) disable iff (rst)
        ale |-> psen_n);
    // R7
    rd_float_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !ad_oe);
    // R7
    rd_pre_float_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_n) |-> !$past(ad_oe));
    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        rd_n || wr_n);
endmodule

// File: rtl/mxb_capture.sv
`timescale 1ns/1ps
module mxb_capture
    import mxb_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  phase_t        phase,
    input  logic          psen_n,
    input  logic          rd_n,
    input  logic [DW-1:0] ad_i,
    output logic [DW-1:0] code,
    output logic          code_vld,
    output logic [DW-1:0] rdata,
    output logic          rdata_vld
);
    logic end_ps, end_rd;
    assign end_ps = !psen_n && (phase == phase_t'(HALF-1) || phase == phase_t'(MC_LEN-1));
    assign end_rd = !rd_n && (phase == phase_t'(HALF-1));

    always_ff @(posedge clk) begin
        if (rst) begin
            code <= '0; code_vld <= 1'b0; rdata <= '0; rdata_vld <= 1'b0;
        end else begin
            code_vld  <= end_ps;
            rdata_vld <= end_rd;
            if (end_ps) code  <= ad_i;
            if (end_rd) rdata <= ad_i;
        end
    end
endmodule

// File: rtl/extbus_sequencer.sv
`timescale 1ns/1ps
module extbus_sequencer
    import mxb_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_pc,
    input  logic [AW-1:0] req_ptr,
    input  logic          req_wide,
    input  logic [DW-1:0] req_port2,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          ale_o,
    output logic          psen_n_o,
    output logic          rd_n_o,
    output logic          wr_n_o,
    output logic [DW-1:0] ad_o,
    output logic          ad_oe_o,
    input  logic [DW-1:0] ad_i,
    output logic [DW-1:0] addr_hi_o,
    output logic [DW-1:0] code_o,
    output logic          code_vld_o,
    output logic [DW-1:0] rdata_o,
    output logic          rdata_vld_o
);
    phase_t phase;
    logic   last;
    cyc_e   cyc;
    acc_t   acc;

    mxb_phase u_phase (.clk(clk), .rst(rst), .phase(phase), .last(last));

    mxb_ctrl u_ctrl (
        .clk(clk), .rst(rst), .last(last), .req_valid(req_valid), .req_op(req_op),
        .req_pc(req_pc), .req_ptr(req_ptr), .req_wide(req_wide), .req_port2(req_port2),
        .req_wdata(req_wdata), .cyc(cyc), .acc(acc), .ready(req_ready)
    );

    mxb_drive u_drive (
        .clk(clk), .rst(rst), .phase(phase), .cyc(cyc), .acc(acc),
        .ale(ale_o), .psen_n(psen_n_o), .rd_n(rd_n_o), .wr_n(wr_n_o),
        .ad_o(ad_o), .ad_oe(ad_oe_o), .addr_hi(addr_hi_o)
    );

    mxb_capture u_cap (
        .clk(clk), .rst(rst), .phase(phase), .psen_n(psen_n_o), .rd_n(rd_n_o),
        .ad_i(ad_i), .code(code_o), .code_vld(code_vld_o),
        .rdata(rdata_o), .rdata_vld(rdata_vld_o)
    );
endmodule

// File: tb/tb_extbus_sequencer.sv
`timescale 1ns/1ps
module tb_extbus_sequencer;
    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, req_wide = 1'b0;
    logic [1:0] req_op = 2'b11;
    logic [15:0] req_pc = '0, req_ptr = '0;
    logic [7:0] req_port2 = '0, req_wdata = '0;
    logic req_ready, ale_o, psen_n_o, rd_n_o, wr_n_o, ad_oe_o, code_vld_o, rdata_vld_o;
    logic [7:0] ad_o, ad_i, addr_hi_o, code_o, rdata_o;

    always #10 clk = ~clk;

    extbus_sequencer dut (.*);

    typedef struct packed {
        logic [1:0] op; logic [15:0] pc; logic [15:0] ptr;
        logic wide; logic [7:0] port2; logic [7:0] wdata;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{2'b00, 16'h1234, 16'h0000, 1'b0, 8'h00, 8'h00},
        '{2'b01, 16'h2000, 16'hBEEF, 1'b1, 8'h00, 8'h00},
        '{2'b01, 16'h20FF, 16'h1177, 1'b0, 8'h3C, 8'h00},
        '{2'b10, 16'h0100, 16'h8001, 1'b1, 8'h00, 8'h5A},
        '{2'b10, 16'h4444, 16'h0099, 1'b0, 8'hC3, 8'hA7},
        '{2'b00, 16'hFFFF, 16'h0000, 1'b0, 8'h00, 8'h00}
    };

    int tests = 0, fails = 0;
    logic [15:0] lat = '0;

    function automatic logic [7:0] fmem(logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction
    assign ad_i = fmem(lat);

    // monitor state
    int n = 0, win = 0;
    int ale_r, ps_cnt, rd_cnt, wr_cnt, rdy_cnt, oe_cnt, nad, ncode, nrd, werr, ferr, wr_bad;
    int ale_run = 0, ps_run = 0;
    logic prev_ale = 1'b0, prev_ps = 1'b1;
    logic [15:0] adr [4];
    logic [7:0] code_l [4];
    logic [7:0] rd_l = '0, exp_wd = '0;

    always @(posedge clk) begin
        #5;
        if (!rst) begin
            if (n < win) begin
                if (ale_o && !prev_ale) ale_r++;
                if (!psen_n_o) ps_cnt++;
                if (!rd_n_o) rd_cnt++;
                if (!wr_n_o) begin
                    wr_cnt++;
                    if (!ad_oe_o || ad_o != exp_wd) wr_bad++;
                end
                if ((!rd_n_o || !psen_n_o) && ad_oe_o) ferr++;
                if (req_ready) rdy_cnt++;
                if (ad_oe_o) oe_cnt++;
            end
            if (!ale_o && prev_ale) begin
                lat = {addr_hi_o, ad_o};
                if (!ad_oe_o) ferr++;
                if (n < win && nad < 4) begin adr[nad] = lat; nad++; end
            end
            if (ale_o) ale_run++;
            else begin
                if (prev_ale && ale_run != 2) werr++;
                ale_run = 0;
            end
            if (!psen_n_o) ps_run++;
            else begin
                if (!prev_ps && ps_run != 3) werr++;
                ps_run = 0;
            end
            if (code_vld_o && ncode < 4) begin code_l[ncode] = code_o; ncode++; end
            if (rdata_vld_o) begin rd_l = rdata_o; nrd++; end
            prev_ale = ale_o;
            prev_ps  = psen_n_o;
            n++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic open_win(input int len);
        win = len; n = 0;
        ale_r = 0; ps_cnt = 0; rd_cnt = 0; wr_cnt = 0; rdy_cnt = 0; oe_cnt = 0;
        nad = 0; ncode = 0; nrd = 0; werr = 0; ferr = 0; wr_bad = 0;
    endtask

    task automatic wait_win();
        do begin @(posedge clk); #8; end while (n < win + 1);
    endtask

    task automatic run_vec(input vec_t v, input bit junk);
        bit dat;
        logic [15:0] d, pn;
        dat = (v.op != 2'b00);
        d   = v.wide ? v.ptr : {v.port2, v.ptr[7:0]};
        pn  = v.pc + 16'd1;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_op = v.op; req_pc = v.pc; req_ptr = v.ptr;
        req_wide = v.wide; req_port2 = v.port2; req_wdata = v.wdata;
        exp_wd = v.wdata;
        open_win(dat ? 24 : 12);
        if (junk) begin
            @(negedge clk);
            req_op = 2'b00; req_pc = 16'h7777;
            repeat (12) @(negedge clk);
        end else begin
            @(negedge clk);
        end
        req_valid = 1'b0;
        wait_win();
        chk(ale_r == (dat ? 3 : 2), "R1/R4 latch pulses", ale_r, dat ? 3 : 2);
        chk(ps_cnt == 6, "R2/R4 program-read clocks", ps_cnt, 6);
        chk(werr == 0, "R1/R2 pulse widths", werr, 0);
        chk(ferr == 0, "R7/R9 bus float and address drive", ferr, 0);
        chk(rdy_cnt == 1, "R10 ready slots", rdy_cnt, 1);
        chk(nad == (dat ? 3 : 2), "R4 address phases", nad, dat ? 3 : 2);
        chk(adr[0] == v.pc, "R9 first address", adr[0], v.pc);
        chk(adr[nad-1] == pn, "R2 second code address", adr[nad-1], pn);
        if (dat) chk(adr[1] == d, v.wide ? "R5 wide data address" : "R6 narrow data address", adr[1], d);
        chk(ncode == 2, "R2 code byte count", ncode, 2);
        chk(code_l[0] == fmem(v.pc), "R2 first code byte", code_l[0], fmem(v.pc));
        chk(code_l[1] == fmem(pn), "R2 second code byte", code_l[1], fmem(pn));
        chk(rd_cnt == (v.op == 2'b01 ? 6 : 0), "R7 read strobe width", rd_cnt, v.op == 2'b01 ? 6 : 0);
        chk(wr_cnt == (v.op == 2'b10 ? 6 : 0), "R8 write strobe width", wr_cnt, v.op == 2'b10 ? 6 : 0);
        chk(wr_bad == 0, "R8 write data on bus", wr_bad, 0);
        if (v.op == 2'b01) begin
            chk(nrd == 1, "R7 read valid count", nrd, 1);
            chk(rd_l == fmem(d), "R7 read data", rd_l, fmem(d));
        end else begin
            chk(nrd == 0, "R7 no read valid", nrd, 0);
        end
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(ale_o == 0 && psen_n_o && rd_n_o && wr_n_o && !ad_oe_o, "R10 strobes idle in reset",
            {ale_o, psen_n_o, rd_n_o, wr_n_o, ad_oe_o}, 5'b01110);
        chk(req_ready == 1, "R10 ready in reset", req_ready, 1);
        rst = 1'b0;

        // R3 idle cycle
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        open_win(12);
        wait_win();
        chk(ale_r == 2, "R1 idle latch pulses", ale_r, 2);
        chk(ps_cnt == 0 && rd_cnt == 0 && wr_cnt == 0, "R3 idle strobes", ps_cnt + rd_cnt + wr_cnt, 0);
        chk(oe_cnt == 0, "R3 idle bus float", oe_cnt, 0);
        chk(werr == 0, "R1 idle pulse width", werr, 0);

        for (int i = 0; i < NV; i++) run_vec(VEC[i], 1'b0);

        // R10 request held during the first cycle of a data access is ignored
        run_vec(VEC[1], 1'b1);
        run_vec(VEC[4], 1'b1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule